// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a per-core countdown timer seen by software as four 32-bit registers on a simple write-strobe/read-mux bus. A control register holds the 8-bit interrupt vector, a one-shot/periodic mode select, a mask bit and a read-only busy flag. A load register holds the start value. A read-only register shows the live count. A divide register selects a power-of-two prescale of the bus clock.

Writing the load register copies the value into the live count and restarts the prescaler. The count then drops by one on every prescaled tick. When it reaches zero the timer expires. In one-shot mode it then rests at zero. In periodic mode it reloads from the load register and runs again. Each expiry with the mask clear raises a request that carries the programmed vector. The request stays up until the core acknowledges it. The usual programming order is load value, then divider, then control with the mask cleared.

Top module: `cdtimer_top`

## Requirements
- R1: After reset the control register reads 0x0001_0000 (masked, one-shot, vector 0, not busy). The load, live-count and divide registers read 0, and `irq_req` is low.
- R2: Register offsets: control 0x320, load 0x380, live count 0x390, divide 0x3E0. Control layout: vector in bits 7:0, busy in bit 12 (read-only), mask in bit 16, mode in bit 17 (1 = periodic). The divide register keeps only bits 3, 1 and 0, and every other bit reads 0. Any other offset reads 0.
- R3: The divide code is {bit3, bit1, bit0}. Code 111 divides by 1. Codes 000 to 110 divide by 2, 4, 8, 16, 32, 64 and 128. One tick occurs every divisor cycles, counted from the load write.
- R4: A write to the load register sets the live count to the written value at that clock edge and restarts the prescale phase. Writing 0 stops the timer.
- R5: While the live count is nonzero, it decreases by exactly one on each tick and holds its value between ticks.
- R6: In one-shot mode, a tick at count 1 expires the timer. The count then stays 0 until the load register is written.
- R7: In periodic mode, a tick at count 1 expires the timer and reloads the count from the load register. A load of N therefore gives one expiry every N ticks.
- R8: An expiry while unmasked sets `irq_req` on the following cycle. `irq_vec` carries the control vector, and the busy bit reads 1 for as long as `irq_req` is high.
- R9: While masked, the count keeps running, but no expiry raises `irq_req`.
- R10: `irq_ack` clears `irq_req` on the next cycle. If an unmasked expiry occurs in the same cycle, the request stays set.
- R11: Writes to the live-count offset have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vec | output | 8 | Vector carried with the request |
| irq_ack | input | 1 | Request acknowledge |

## Verification
A wrong prescale phase or a faulty decrement shows up in the live-count register within one divisor period of the bad cycle, because that register is compared every clock. A wrong reload or expiry decision shows up within one cycle: the count either fails to return to the load value or fails to stay at zero, and `irq_req` rises or falls a cycle off. A stale mask or a bad acknowledge priority shows up on `irq_req` and the busy bit one cycle after the affected expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFF_CTRL = 12'h320;
  localparam logic [BUS_AW-1:0] OFF_LOAD = 12'h380;
  localparam logic [BUS_AW-1:0] OFF_LIVE = 12'h390;
  localparam logic [BUS_AW-1:0] OFF_DIV  = 12'h3E0;

  localparam int unsigned CTRL_MODE_BIT = 17;
  localparam int unsigned CTRL_MASK_BIT = 16;
  localparam int unsigned CTRL_BUSY_BIT = 12;
  localparam int unsigned VEC_W         = 8;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e        mode;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } tmr_ctrl_t;

  // divide code -> log2 of divisor; 111 is divide-by-1
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == 3'b111) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int unsigned PRE_W = 7,
  localparam int unsigned SH_W = $clog2(PRE_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d, lim;
  logic [PRE_W:0]   one_sh;
  logic             cnt_en;

  always_comb begin
    one_sh = (PRE_W + 1)'(1) << shift;
    lim    = PRE_W'(one_sh - 1'b1);
    tick   = run & (cnt_q >= lim);
    cnt_en = clr | run;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));

  // R3
  prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic          periodic,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cur,
  output logic          expire
);
  logic [CW-1:0] cur_q, cur_d;
  logic          cur_en;
  logic          at_one;

  always_comb begin
    at_one = (cur_q == CW'(1));
    expire = tick & ~load & at_one;
    cur_en = load | tick;
    cur_d  = cur_q;
    if (load) begin
      cur_d = load_val;
    end else if (tick && (cur_q != '0)) begin
      if (at_one) cur_d = periodic ? reload_val : '0;
      else        cur_d = cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign cur = cur_q;

  // R6
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q == '0) && !load) |=> (cur_q == '0));

  // R7
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur_q == $past(reload_val)));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (cur_q > CW'(1))) |=> (cur_q == $past(cur_q) - 1'b1));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(load_val)));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [BUS_AW-1:0]   addr,
  input  logic [BUS_DW-1:0]   wdata,
  output logic [BUS_DW-1:0]   rdata,
  input  logic [CW-1:0]       live,
  input  logic                expire,
  input  logic                irq_ack,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vec,
  output logic                load_wr,
  output logic [CW-1:0]       load_q,
  output logic                periodic,
  output logic [2:0]          shift
);
  tmr_ctrl_t     ctrl_q, ctrl_d;
  logic [2:0]    divc_q, divc_d;
  logic [CW-1:0] load_d;
  logic          req_q, req_d;
  logic          ctrl_wr, div_wr;
  logic [BUS_DW-1:0] ctrl_rd, div_rd;

  always_comb begin
    ctrl_wr = we && (addr == OFF_CTRL);
    div_wr  = we && (addr == OFF_DIV);
    load_wr = we && (addr == OFF_LOAD);

    ctrl_d      = ctrl_q;
    ctrl_d.mode = tmr_mode_e'(wdata[CTRL_MODE_BIT]);
    ctrl_d.mask = wdata[CTRL_MASK_BIT];
    ctrl_d.vec  = wdata[VEC_W-1:0];

    divc_d = {wdata[3], wdata[1], wdata[0]};
    load_d = wdata[CW-1:0];

    req_d = (req_q & ~irq_ack) | (expire & ~ctrl_q.mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.mode <= MODE_ONESHOT;
      ctrl_q.mask <= 1'b1;
      ctrl_q.vec  <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      divc_q <= '0;
    else if (div_wr) divc_q <= divc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (load_wr) load_q <= load_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[VEC_W-1:0]    = ctrl_q.vec;
    ctrl_rd[CTRL_BUSY_BIT] = req_q;
    ctrl_rd[CTRL_MASK_BIT] = ctrl_q.mask;
    ctrl_rd[CTRL_MODE_BIT] = ctrl_q.mode;
    div_rd    = '0;
    div_rd[3] = divc_q[2];
    div_rd[1] = divc_q[1];
    div_rd[0] = divc_q[0];
    unique case (addr)
      OFF_CTRL: rdata = ctrl_rd;
      OFF_LOAD: rdata = BUS_DW'(load_q);
      OFF_LIVE: rdata = BUS_DW'(live);
      OFF_DIV:  rdata = div_rd;
      default:  rdata = '0;
    endcase
  end

  assign irq_req  = req_q;
  assign irq_vec  = ctrl_q.vec;
  assign periodic = (ctrl_q.mode == MODE_PERIODIC);
  assign shift    = div_shift(divc_q);

  // R8
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.mask) |=> irq_req);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && (!expire || ctrl_q.mask)) |=> !irq_req);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !expire) |=> !irq_req);

  // R2
  div_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_DIV) |-> ((rdata & ~32'h0000_000B) == '0));
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_req,
  output logic [7:0]  irq_vec,
  input  logic        irq_ack
);
  localparam int unsigned SH_W = $clog2(PRE_W + 1);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             load_wr, periodic, tick, expire;
  logic [CNT_W-1:0] load_q, live;
  logic [2:0]       shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  cdt_regs #(.CW(CNT_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .live     (live),
    .expire   (expire),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .load_wr  (load_wr),
    .load_q   (load_q),
    .periodic (periodic),
    .shift    (shift)
  );

  cdt_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (load_wr),
    .run   (live != '0),
    .shift (SH_W'(shift)),
    .tick  (tick)
  );

  cdt_count #(.CW(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load       (load_wr),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .tick       (tick),
    .periodic   (periodic),
    .reload_val (load_q),
    .cur        (live),
    .expire     (expire)
  );
endmodule

// File: tb/cdtimer_top_tb_top.sv
module cdtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = 12'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        irq_ack = 1'b0;

  always #2 clk = ~clk;

  cdtimer_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  // behavioural reference state
  int unsigned m_vec, m_div, m_pre, m_dv;
  bit          m_mode, m_mask, m_req, m_tk, m_ex;
  logic [31:0] m_init, m_cur, exp_rd;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  string       cur_req = "R1";
  bit          done = 0;

  initial begin
    m_vec = 0; m_mode = 0; m_mask = 1; m_div = 0;
    m_init = 0; m_cur = 0; m_pre = 0; m_req = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      m_dv = (m_div == 7) ? 1 : (2 << m_div);
      m_tk = (m_cur != 0) && (m_pre >= m_dv - 1);
      m_ex = 0;
      if (bus_we && bus_addr == 12'h380) begin
        m_init = bus_wdata; m_cur = bus_wdata; m_pre = 0;
      end else if (m_cur != 0) begin
        if (m_tk) begin
          m_pre = 0;
          if (m_cur == 1) begin
            m_ex = 1;
            m_cur = m_mode ? m_init : 32'h0;
          end else m_cur = m_cur - 1;
        end else m_pre = m_pre + 1;
      end
      m_req = (m_req && !irq_ack) || (m_ex && !m_mask);
      if (bus_we && bus_addr == 12'h320) begin
        m_vec = bus_wdata[7:0]; m_mask = bus_wdata[16]; m_mode = bus_wdata[17];
      end
      if (bus_we && bus_addr == 12'h3E0)
        m_div = {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      case (bus_addr)
        12'h320: exp_rd = {14'h0, m_mode, m_mask, 3'b0, m_req, 4'h0, m_vec[7:0]};
        12'h380: exp_rd = m_init;
        12'h390: exp_rd = m_cur;
        12'h3E0: exp_rd = {28'h0, m_div[2], 1'b0, m_div[1:0]};
        default: exp_rd = 32'h0;
      endcase
      n_chk++;
      if (bus_rdata !== exp_rd || irq_req !== m_req || irq_vec !== m_vec[7:0]) begin
        n_fail++;
        $display("FAIL %s addr=%h rdata=%h exp=%h req=%b exp=%b vec=%h exp=%h",
                 cur_req, bus_addr, bus_rdata, exp_rd, irq_req, m_req, irq_vec, m_vec[7:0]);
      end
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic watch(input logic [11:0] a, input int n);
    bus_addr = a;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(posedge clk); #1;
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    cur_req = "R1";
    watch(12'h320, 2); watch(12'h380, 2); watch(12'h390, 2); watch(12'h3E0, 2);
    cur_req = "R2";
    wr(12'h3E0, 32'hFFFF_FFFF); watch(12'h3E0, 2);
    wr(12'h320, 32'hFFFF_FFFF); watch(12'h320, 2);
    watch(12'h7FC, 2);
    cur_req = "R11";
    wr(12'h390, 32'h0000_0005); watch(12'h390, 2); watch(12'h380, 2);
    // one-shot, divide by 1
    cur_req = "R6";
    wr(12'h3E0, 32'h0000_000B);
    wr(12'h320, 32'h0000_0041);
    cur_req = "R5";
    wr(12'h380, 32'd5); watch(12'h390, 10);
    cur_req = "R8";
    watch(12'h320, 3); ack_pulse(); watch(12'h320, 3);
    // periodic, divide by 2
    cur_req = "R7";
    wr(12'h3E0, 32'h0);
    wr(12'h320, 32'h0002_0077);
    wr(12'h380, 32'd3);
    for (int i = 0; i < 4; i++) begin
      watch(12'h390, 5); ack_pulse();
    end
    cur_req = "R3";
    wr(12'h3E0, 32'h0000_0002); watch(12'h390, 60);
    // ack held while expiries keep arriving
    cur_req = "R10";
    wr(12'h3E0, 32'h0000_000B);
    wr(12'h380, 32'd2);
    irq_ack = 1'b1; watch(12'h320, 12); irq_ack = 1'b0; watch(12'h320, 3);
    ack_pulse(); watch(12'h320, 1);
    // masked periodic keeps counting
    cur_req = "R9";
    wr(12'h320, 32'h0003_0022);
    ack_pulse();
    wr(12'h380, 32'd4); watch(12'h390, 20); watch(12'h320, 5);
    cur_req = "R4";
    wr(12'h380, 32'd0); watch(12'h390, 10);
    wr(12'h380, 32'd7); watch(12'h390, 3);
    wr(12'h380, 32'd9); watch(12'h390, 4);
    // slowest divider
    cur_req = "R3";
    wr(12'h320, 32'h0000_0055);
    wr(12'h3E0, 32'h0000_000A);
    wr(12'h380, 32'd2); watch(12'h390, 300); watch(12'h320, 4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule